// File: doc/BRIEF.md
# PC-Relative Conditional Branch Unit

This block works out the next program counter for the short conditional branches of a small 32-bit processor. Each cycle in which the valid strobe is high, it takes the fetched 16-bit instruction word, the address of that instruction and five compare flags left by the last compare. One clock later it presents the next program counter, a taken indication and an illegal-instruction flag.

A short branch is marked by a selector bit in the word. It carries a four-bit condition code and a ten-bit signed offset counted in halfwords. Signed and unsigned orderings come from separate flags, and the "or equal" conditions combine them with the equality flag. Condition codes with no meaning are reported as illegal. So are the retired long absolute-branch encodings of the other format. In both cases the program counter is left where it was.

The fetch stage uses the registered outputs to redirect. Flag generation, fetch and exception entry are left to the neighbouring stages.

Top module: `brn_unit`

## Requirements
- R1: A word with bit 14 set is a short branch. Bits 13:10 are its condition code. Bits 9:0 are a two's-complement halfword offset, which is sign-extended and doubled. A taken branch sets the next PC to the instruction address plus that byte offset.
- R2: The flag input is ordered bit 0 EQ, bit 1 LT, bit 2 GT, bit 3 LTU, bit 4 GTU. The branch is taken under these conditions:
  - code 0: EQ
  - code 1: EQ clear
  - code 2: LT
  - code 3: GT
  - code 4: LTU
  - code 5: GTU
- R3: Code 6 is taken on GT or EQ. Code 7 is taken on LT or EQ. Code 8 is taken on GTU or EQ. Code 9 is taken on LTU or EQ.
- R4: When a defined branch is not taken, taken is low, illegal is low and the next PC is the instruction address plus 2.
- R5: A short branch with code 10 to 15 sets illegal, keeps taken low and gives the instruction address unchanged as next PC.
- R6: A word with bit 14 clear whose upper byte (bits 15:8) lies in 0x0F to 0x18 is a retired long branch. It sets illegal, keeps taken low and gives the address unchanged.
- R7: Any other word with bit 14 clear, including upper bytes 0x0E and 0x19, leaves taken and illegal low and gives the address plus 2.
- R8: All target arithmetic is 32-bit and wraps modulo 2^32, with nothing reported.
- R9: The outputs change only on the clock edge at which valid is high. They show that cycle's result one clock later and hold while valid is low.
- R10: An active-low reset clears the next PC, taken and illegal to zero at once. Its release is synchronized, so valid is honoured from the third rising edge after release.

Reset in detail: while the reset input is low, all three outputs read zero. After the reset input rises, valid is ignored at the first two rising edges and is honoured from the third one on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction, address and flags are valid this cycle |
| instr_i | input | 16 | Fetched instruction word |
| pc_i | input | 32 | Address of the instruction |
| flags_i | input | 5 | Compare flags {GTU, LTU, GT, LT, EQ} |
| next_pc_o | output | 32 | Resolved next program counter |
| taken_o | output | 1 | Branch was taken |
| illegal_o | output | 1 | Undefined or retired encoding |

## Verification
Every defined condition code is run against each single-flag pattern and against no flags at all. A swapped flag index or a missing equality term in an "or equal" code would then show up as a wrong taken bit and a wrong target.

The offset is driven at its extremes: +511, -512, -1 and 0. A design that zero-extends, forgets the doubling or adds 2 on the taken path would give the wrong target. Targets that wrap past the top and the bottom of the address space catch a design that truncates or saturates.

The illegal range is probed on both sides of each boundary. Codes 9 and 10 are driven, as are upper bytes 0x0E, 0x0F, 0x18 and 0x19. An off-by-one range, or a design that advances the PC on an illegal word, would be caught.

Outputs are also watched while valid is low and across a reset issued mid-run. A design that loads on every cycle, or clears only on a clock edge, would fail there.

// File: rtl/brn_pkg.sv
package brn_pkg;
  localparam int INSTR_W = 16;
  localparam int FMT_BIT = 14;
  localparam int OPC_W   = 4;
  localparam int OFF_W   = 10;
  localparam int FLAG_W  = 5;
  localparam int MAJOR_W = 8;
  localparam logic [MAJOR_W-1:0] LEGACY_LO = 8'h0F;
  localparam logic [MAJOR_W-1:0] LEGACY_HI = 8'h18;

  typedef enum logic [OPC_W-1:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_GT  = 4'd3,
    CC_LTU = 4'd4,
    CC_GTU = 4'd5,
    CC_GE  = 4'd6,
    CC_LE  = 4'd7,
    CC_GEU = 4'd8,
    CC_LEU = 4'd9
  } cond_e;

  typedef struct packed {
    logic gtu;
    logic ltu;
    logic gt;
    logic lt;
    logic eq;
  } flags_t;
endpackage

// File: rtl/brn_decode.sv
module brn_decode
  import brn_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               is_branch,
  output logic               is_legacy,
  output logic [OPC_W-1:0]   opc,
  output logic [OFF_W-1:0]   off
);
  logic [MAJOR_W-1:0] major;

  always_comb begin
    major     = instr[INSTR_W-1 -: MAJOR_W];
    is_branch = instr[FMT_BIT];
    opc       = instr[FMT_BIT-1 -: OPC_W];
    off       = instr[OFF_W-1:0];
    is_legacy = !instr[FMT_BIT] && (major >= LEGACY_LO) && (major <= LEGACY_HI);
  end
endmodule

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  flags_t           flags,
  output logic             take,
  output logic             undef
);
  always_comb begin
    take  = 1'b0;
    undef = 1'b0;
    case (opc)
      CC_EQ:   take = flags.eq;
      CC_NE:   take = !flags.eq;
      CC_LT:   take = flags.lt;
      CC_GT:   take = flags.gt;
      CC_LTU:  take = flags.ltu;
      CC_GTU:  take = flags.gtu;
      CC_GE:   take = flags.gt  | flags.eq;
      CC_LE:   take = flags.lt  | flags.eq;
      CC_GEU:  take = flags.gtu | flags.eq;
      CC_LEU:  take = flags.ltu | flags.eq;
      default: undef = 1'b1;
    endcase
  end
endmodule

// File: rtl/brn_target.sv
module brn_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 10
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  jump_pc,
  output logic [PC_W-1:0]  seq_pc
);
  localparam int EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] byte_off;

  always_comb begin
    byte_off = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
    jump_pc  = pc + byte_off;
    seq_pc   = pc + PC_W'(2);
  end
endmodule

// File: rtl/brn_unit.sv
module brn_unit
  import brn_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               taken_o,
  output logic               illegal_o
);
  logic            rst_meta_n;
  logic            rst_sync_n;
  logic            is_branch;
  logic            is_legacy;
  logic [OPC_W-1:0] opc;
  logic [OFF_W-1:0] off;
  logic            take;
  logic            undef;
  logic [PC_W-1:0] jump_pc;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] pc_d;
  logic            taken_d;
  logic            illegal_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  brn_decode u_decode (
    .instr     (instr_i),
    .is_branch (is_branch),
    .is_legacy (is_legacy),
    .opc       (opc),
    .off       (off)
  );

  brn_cond_eval u_cond (
    .opc   (opc),
    .flags (flags_t'(flags_i)),
    .take  (take),
    .undef (undef)
  );

  brn_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
    .pc      (pc_i),
    .off     (off),
    .jump_pc (jump_pc),
    .seq_pc  (seq_pc)
  );

  always_comb begin
    pc_d      = seq_pc;
    taken_d   = 1'b0;
    illegal_d = 1'b0;
    if (is_branch) begin
      if (undef) begin
        pc_d      = pc_i;
        illegal_d = 1'b1;
      end else if (take) begin
        pc_d    = jump_pc;
        taken_d = 1'b1;
      end
    end else if (is_legacy) begin
      pc_d      = pc_i;
      illegal_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else if (valid_i) begin
      next_pc_o <= pc_d;
      taken_o   <= taken_d;
      illegal_o <= illegal_d;
    end
  end
endmodule

// File: rtl/brn_unit_chk.sv
module brn_unit_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic            valid_i,
  input logic [15:0]     instr_i,
  input logic [PC_W-1:0] pc_i,
  input logic [4:0]      flags_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic            taken_o,
  input logic            illegal_o
);
  logic undef_in;
  logic legacy_in;
  logic defined_in;

  always_comb begin
    undef_in   = instr_i[14] && (instr_i[13:10] >= 4'd10);
    legacy_in  = !instr_i[14] && (instr_i[15:8] >= 8'h0F) && (instr_i[15:8] <= 8'h18);
    defined_in = instr_i[14] && (instr_i[13:10] < 4'd10);
  end

  // R2
  eq_cond_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && instr_i[14] && instr_i[13:10] == 4'd0) |=> (taken_o == $past(flags_i[0])));

  // R4
  fallthru_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && defined_in) |=> (!illegal_o && (taken_o || next_pc_o == $past(pc_i) + PC_W'(2))));

  // R5
  undef_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && undef_in) |=> (illegal_o && !taken_o && next_pc_o == $past(pc_i)));

  // R6
  legacy_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && legacy_in) |=> (illegal_o && !taken_o && next_pc_o == $past(pc_i)));

  // R7
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !instr_i[14] && !legacy_in) |=> (!illegal_o && !taken_o && next_pc_o == $past(pc_i) + PC_W'(2)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(illegal_o)));

  // R5
  excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    taken_o |-> !illegal_o);
endmodule

bind brn_unit brn_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .valid_i    (valid_i),
  .instr_i    (instr_i),
  .pc_i       (pc_i),
  .flags_i    (flags_i),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .illegal_o  (illegal_o)
);

// File: tb/brn_unit_tb_top.sv
`timescale 1ns/1ps
module brn_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic [15:0] instr_i;
  logic [31:0] pc_i;
  logic [4:0]  flags_i;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  brn_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (valid_i),
    .instr_i   (instr_i),
    .pc_i      (pc_i),
    .flags_i   (flags_i),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .illegal_o (illegal_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] ins, input logic [31:0] pc, input logic [4:0] fl);
    @(negedge clk);
    instr_i = ins;
    pc_i    = pc;
    flags_i = fl;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  function automatic logic want_take(input int op, input logic [4:0] f);
    case (op)
      0: return f[0];
      1: return !f[0];
      2: return f[1];
      3: return f[2];
      4: return f[3];
      5: return f[4];
      6: return f[2] | f[0];
      7: return f[1] | f[0];
      8: return f[4] | f[0];
      9: return f[3] | f[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] br(input int op, input logic [9:0] off);
    return {2'b01, op[3:0], off};
  endfunction

  task automatic t_reset();
    chk("R10", "reset pc", next_pc_o, 32'h0);
    chk("R10", "reset taken", {31'b0, taken_o}, 32'h0);
    chk("R10", "reset illegal", {31'b0, illegal_o}, 32'h0);
  endtask

  task automatic t_conditions();
    logic [4:0] pats [6] = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000};
    for (int op = 0; op < 10; op++) begin
      for (int p = 0; p < 6; p++) begin
        logic tk;
        string tag;
        tk = want_take(op, pats[p]);
        tag = tk ? ((op < 6) ? "R2" : "R3") : "R4";
        drive(br(op, 10'd8), 32'h0000_2000, pats[p]);
        chk(tag, $sformatf("op%0d flags%b taken", op, pats[p]), {31'b0, taken_o}, {31'b0, tk});
        chk(tag, $sformatf("op%0d flags%b pc", op, pats[p]), next_pc_o, tk ? 32'h0000_2010 : 32'h0000_2002);
        chk(tag, $sformatf("op%0d illegal", op), {31'b0, illegal_o}, 32'h0);
      end
    end
  endtask

  task automatic t_offsets();
    drive(br(0, 10'h1FF), 32'h0000_1000, 5'b00001);
    chk("R1", "off +511", next_pc_o, 32'h0000_13FE);
    drive(br(0, 10'h200), 32'h0000_1000, 5'b00001);
    chk("R1", "off -512", next_pc_o, 32'h0000_0C00);
    drive(br(0, 10'h3FF), 32'h0000_1000, 5'b00001);
    chk("R1", "off -1", next_pc_o, 32'h0000_0FFE);
    drive(br(0, 10'h000), 32'h0000_1000, 5'b00001);
    chk("R1", "off 0", next_pc_o, 32'h0000_1000);
    chk("R1", "off 0 taken", {31'b0, taken_o}, 32'h1);
  endtask

  task automatic t_wrap();
    drive(br(1, 10'd16), 32'hFFFF_FFF0, 5'b00000);
    chk("R8", "wrap up", next_pc_o, 32'h0000_0010);
    drive(br(1, 10'h3F0), 32'h0000_0010, 5'b00000);
    chk("R8", "wrap down", next_pc_o, 32'hFFFF_FFF0);
    drive(br(0, 10'd4), 32'hFFFF_FFFE, 5'b00000);
    chk("R8", "wrap seq", next_pc_o, 32'h0000_0000);
  endtask

  task automatic t_undefined();
    for (int op = 10; op < 16; op++) begin
      drive(br(op, 10'd8), 32'h0000_3000, 5'b11111);
      chk("R5", $sformatf("op%0d illegal", op), {31'b0, illegal_o}, 32'h1);
      chk("R5", $sformatf("op%0d taken", op), {31'b0, taken_o}, 32'h0);
      chk("R5", $sformatf("op%0d pc", op), next_pc_o, 32'h0000_3000);
    end
  endtask

  task automatic t_legacy();
    logic [7:0] ill [3] = '{8'h0F, 8'h13, 8'h18};
    logic [7:0] ok  [3] = '{8'h0E, 8'h19, 8'h80};
    for (int i = 0; i < 3; i++) begin
      drive({ill[i], 8'h00}, 32'h0000_4000, 5'b11111);
      chk("R6", $sformatf("major %h illegal", ill[i]), {31'b0, illegal_o}, 32'h1);
      chk("R6", $sformatf("major %h pc", ill[i]), next_pc_o, 32'h0000_4000);
      chk("R6", $sformatf("major %h taken", ill[i]), {31'b0, taken_o}, 32'h0);
    end
    for (int i = 0; i < 3; i++) begin
      drive({ok[i], 8'h23}, 32'h0000_4000, 5'b11111);
      chk("R7", $sformatf("major %h illegal", ok[i]), {31'b0, illegal_o}, 32'h0);
      chk("R7", $sformatf("major %h taken", ok[i]), {31'b0, taken_o}, 32'h0);
      chk("R7", $sformatf("major %h pc", ok[i]), next_pc_o, 32'h0000_4002);
    end
  endtask

  task automatic t_hold();
    drive(br(0, 10'd2), 32'h0000_5000, 5'b00001);
    chk("R9", "load pc", next_pc_o, 32'h0000_5004);
    @(negedge clk);
    instr_i = 16'h7C00;
    pc_i    = 32'h1234_5678;
    flags_i = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R9", "hold pc", next_pc_o, 32'h0000_5004);
    chk("R9", "hold taken", {31'b0, taken_o}, 32'h1);
    chk("R9", "hold illegal", {31'b0, illegal_o}, 32'h0);
  endtask

  task automatic t_midreset();
    drive(br(12, 10'd0), 32'h0000_6000, 5'b00000);
    chk("R10", "pre-reset illegal", {31'b0, illegal_o}, 32'h1);
    #1 rst_n = 1'b0;
    #1;
    chk("R10", "async clear pc", next_pc_o, 32'h0);
    chk("R10", "async clear illegal", {31'b0, illegal_o}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "post-reset pc", next_pc_o, 32'h0);
    drive(br(0, 10'd4), 32'h0000_7000, 5'b00001);
    chk("R10", "resume after release", next_pc_o, 32'h0000_7008);
  endtask

  initial begin
    rst_n   = 1'b0;
    valid_i = 1'b0;
    instr_i = '0;
    pc_i    = '0;
    flags_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_conditions();
    t_offsets();
    t_wrap();
    t_undefined();
    t_legacy();
    t_hold();
    t_midreset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule